// File: doc/BRIEF.md
# Coprocessor Halt-and-Restart Run Controller

This block is the run-control logic of a small low-power coprocessor. It owns the "running" state of the core and decides when the program counter must be reloaded. The host starts the core with a start pulse. From then on the program itself manages sleeping: a halt instruction stops the core and starts a sleep counter. When the counter reaches the period in the currently selected period register, the core restarts from the start address.

The program picks one of five externally held period registers with a select instruction. An end instruction with its wake flag set pulses a wakeup request to the host, and execution carries on. A separate timer-clear event disarms automatic restarts. The program still runs on to its next halt, but after that it stays stopped until the host starts it again. The instruction datapath is outside this block. It sees only the instruction word that the core presents, qualified by a valid strobe.

Top module: `lp_run_ctrl`

## Requirements
- R1: After reset `run_o`, `pc_load_o` and `wake_o` are low, automatic restarts are disarmed and period index 0 is selected; no instruction or time passing starts the core before a host start.
- R2: A `host_start_i` pulse raises `run_o` on the next cycle, arms automatic restarts and gives a one-cycle `pc_load_o` with `pc_addr_o` equal to `start_addr_i`; a host start wins over a halt presented in the same cycle.
- R3: A halt instruction (`insn_i[31:28]` = 11) accepted while running drops `run_o` on the next cycle.
- R4: After a halt with restarts armed, `run_o` stays low for P+1 cycles, where P is the selected period; it then rises together with a one-cycle `pc_load_o` carrying the start address. A period of zero gives a single stopped cycle.
- R5: A select instruction (`insn_i[31:28]` = 9, `insn_i[27:25]` = 1) loads the period index from `insn_i[3:0]`; it governs every later sleep.
- R6: A select index of 5 or more selects period register 4.
- R7: An end instruction (`insn_i[31:28]` = 9, `insn_i[27:25]` = 0) with `insn_i[0]` = 1 gives a one-cycle `wake_o` pulse on the next cycle and leaves `run_o` high; with `insn_i[0]` = 0 there is no pulse.
- R8: A `tmr_clr_i` pulse, whether given while running or while asleep, prevents any automatic restart until the next host start.
- R9: Instructions presented while `run_o` is low have no effect: no wake pulse and no change of period index.
- R10: `pc_load_o` is only ever high while `run_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_start_i | input | 1 | Host start pulse |
| start_addr_i | input | PC_W | Program start address in words |
| periods_i | input | NUM_PERIODS*CNT_W | Period registers, entry k at bits [k*CNT_W +: CNT_W] |
| insn_valid_i | input | 1 | Instruction word valid this cycle |
| insn_i | input | 32 | Instruction word being executed |
| tmr_clr_i | input | 1 | Disarm automatic restarts |
| run_o | output | 1 | Core running |
| pc_load_o | output | 1 | One-cycle PC load strobe |
| pc_addr_o | output | PC_W | Address to load into the PC |
| wake_o | output | 1 | One-cycle host wakeup request |

## Verification
The bench builds the block with five period registers of 8 bits and an 11-bit PC. It loads them with short, distinct periods, one of which is zero. This keeps every sleep down to a few cycles, so the bench can sweep all 16 select index values, including every clamped one. Each stopped interval is measured and compared with the period picked by the index, plus one. Disarm, idle-instruction and start-versus-halt cases are run against the same small configuration.

// File: rtl/lp_rc_pkg.sv
package lp_rc_pkg;
  localparam logic [3:0] OPC_HALT = 4'd11;
  localparam logic [3:0] OPC_END  = 4'd9;
  localparam logic [2:0] SUB_WAKE = 3'd0;
  localparam logic [2:0] SUB_SEL  = 3'd1;

  typedef struct packed {
    logic       halt;
    logic       wake;
    logic       sel;
    logic [3:0] sel_idx;
  } rc_evt_t;
endpackage

// File: rtl/lp_rc_decode.sv
module lp_rc_decode
  import lp_rc_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] insn_i,
  output rc_evt_t     evt_o
);
  logic [3:0] major;
  logic [2:0] sub;
  logic       unused_bits;

  assign major       = insn_i[31:28];
  assign sub         = insn_i[27:25];
  assign unused_bits = ^insn_i[24:4];

  always_comb begin
    evt_o = '0;
    if (valid_i) begin
      evt_o.halt    = (major == OPC_HALT);
      evt_o.wake    = (major == OPC_END) && (sub == SUB_WAKE) && insn_i[0];
      evt_o.sel     = (major == OPC_END) && (sub == SUB_SEL);
      evt_o.sel_idx = insn_i[3:0];
    end
  end
endmodule

// File: rtl/lp_rc_period_sel.sv
module lp_rc_period_sel #(
  parameter int NUM_PERIODS = 5,
  parameter int CNT_W       = 16,
  localparam int SEL_W      = $clog2(NUM_PERIODS)
) (
  input  logic [NUM_PERIODS*CNT_W-1:0] periods_i,
  input  logic [SEL_W-1:0]             sel_i,
  output logic [CNT_W-1:0]             period_o
);
  logic [CNT_W-1:0] slot [NUM_PERIODS];

  for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_slot
    assign slot[g] = periods_i[g*CNT_W +: CNT_W];
  end

  always_comb begin
    period_o = '0;
    for (int k = 0; k < NUM_PERIODS; k++) begin
      if (sel_i == SEL_W'(k)) period_o = slot[k];
    end
  end
endmodule

// File: rtl/lp_rc_sleep_timer.sv
module lp_rc_sleep_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             cancel_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             sleep_q;

  // >= rather than == so a period lowered mid-sleep cannot wrap the counter
  assign expire_o = sleep_q && (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sleep_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q   <= '0;
      sleep_q <= 1'b1;
    end else if (cancel_i || expire_o) begin
      sleep_q <= 1'b0;
    end else if (sleep_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lp_run_ctrl.sv
module lp_run_ctrl
  import lp_rc_pkg::*;
#(
  parameter int NUM_PERIODS = 5,
  parameter int CNT_W       = 16,
  parameter int PC_W        = 11
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         host_start_i,
  input  logic [PC_W-1:0]              start_addr_i,
  input  logic [NUM_PERIODS*CNT_W-1:0] periods_i,
  input  logic                         insn_valid_i,
  input  logic [31:0]                  insn_i,
  input  logic                         tmr_clr_i,
  output logic                         run_o,
  output logic                         pc_load_o,
  output logic [PC_W-1:0]              pc_addr_o,
  output logic                         wake_o
);
  localparam int SEL_W = $clog2(NUM_PERIODS);

  rc_evt_t          evt;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] period;
  logic             run_q, tmr_en_q, tmr_en_d;
  logic             halt_acc, arm, restart, expire, pc_load_d;

  lp_rc_decode u_decode (
    .valid_i (insn_valid_i && run_q),
    .insn_i  (insn_i),
    .evt_o   (evt)
  );

  lp_rc_period_sel #(.NUM_PERIODS(NUM_PERIODS), .CNT_W(CNT_W)) u_psel (
    .periods_i (periods_i),
    .sel_i     (sel_q),
    .period_o  (period)
  );

  lp_rc_sleep_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm),
    .cancel_i (!tmr_en_q || tmr_clr_i || host_start_i),
    .period_i (period),
    .expire_o (expire)
  );

  always_comb begin
    int unsigned idx;
    idx   = 32'(evt.sel_idx);
    sel_d = sel_q;
    if (evt.sel) sel_d = (idx >= NUM_PERIODS) ? SEL_W'(NUM_PERIODS - 1) : SEL_W'(idx);
  end

  assign tmr_en_d  = host_start_i ? 1'b1 : (tmr_clr_i ? 1'b0 : tmr_en_q);
  assign halt_acc  = evt.halt && !host_start_i;
  assign arm       = halt_acc && tmr_en_d;
  assign restart   = expire && tmr_en_q && !tmr_clr_i && !host_start_i;
  assign pc_load_d = host_start_i || restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      tmr_en_q  <= 1'b0;
      sel_q     <= '0;
      pc_load_o <= 1'b0;
      pc_addr_o <= '0;
      wake_o    <= 1'b0;
    end else begin
      tmr_en_q  <= tmr_en_d;
      sel_q     <= sel_d;
      pc_load_o <= pc_load_d;
      wake_o    <= evt.wake;
      if (pc_load_d) begin
        run_q     <= 1'b1;
        pc_addr_o <= start_addr_i;
      end else if (halt_acc) begin
        run_q <= 1'b0;
      end
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/lp_run_ctrl_chk.sv
module lp_run_ctrl_chk #(
  parameter int PC_W = 11
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            host_start_i,
  input logic [PC_W-1:0] start_addr_i,
  input logic            insn_valid_i,
  input logic [31:0]     insn_i,
  input logic            run_o,
  input logic            pc_load_o,
  input logic [PC_W-1:0] pc_addr_o,
  input logic            wake_o,
  input logic            tmr_en_q
);
  assert_load_in_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> run_o);

  assert_load_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> pc_addr_o == $past(start_addr_i));

  assert_halt_stops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && insn_valid_i && insn_i[31:28] == 4'd11 && !host_start_i) |=> !run_o);

  assert_rise_loads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> pc_load_o);

  assert_wake_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(insn_valid_i && run_o));

  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_en_q && !run_o && !host_start_i) |=> !run_o);
endmodule

bind lp_run_ctrl lp_run_ctrl_chk #(.PC_W(PC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_start_i (host_start_i),
  .start_addr_i (start_addr_i),
  .insn_valid_i (insn_valid_i),
  .insn_i       (insn_i),
  .run_o        (run_o),
  .pc_load_o    (pc_load_o),
  .pc_addr_o    (pc_addr_o),
  .wake_o       (wake_o),
  .tmr_en_q     (tmr_en_q)
);

// File: tb/lp_run_ctrl_bench.sv
`timescale 1ns/1ps
module lp_run_ctrl_bench;
  localparam int NP = 5;
  localparam int CW = 8;
  localparam int PW = 11;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          host_start = 1'b0;
  logic [PW-1:0] start_addr = 11'h155;
  logic [NP*CW-1:0] periods;
  logic          insn_valid = 1'b0;
  logic [31:0]   insn = '0;
  logic          tmr_clr = 1'b0;
  logic          run, pc_load, wake;
  logic [PW-1:0] pc_addr;

  int per [NP] = '{3, 0, 7, 12, 5};
  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  for (genvar g = 0; g < NP; g++) begin : g_per
    assign periods[g*CW +: CW] = CW'(per[g]);
  end

  lp_run_ctrl #(.NUM_PERIODS(NP), .CNT_W(CW), .PC_W(PW)) u_lp_run_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .host_start_i(host_start), .start_addr_i(start_addr),
    .periods_i(periods), .insn_valid_i(insn_valid), .insn_i(insn), .tmr_clr_i(tmr_clr),
    .run_o(run), .pc_load_o(pc_load), .pc_addr_o(pc_addr), .wake_o(wake)
  );

  function automatic logic [31:0] i_halt();
    return {4'd11, 28'd0};
  endfunction
  function automatic logic [31:0] i_end(bit w);
    return {4'd9, 3'd0, 24'd0, w};
  endfunction
  function automatic logic [31:0] i_sel(int i);
    return {4'd9, 3'd1, 21'd0, 4'(i)};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic issue(logic [31:0] w);
    insn_valid = 1'b1; insn = w;
    step();
    insn_valid = 1'b0; insn = '0;
  endtask

  task automatic start();
    host_start = 1'b1;
    step();
    host_start = 1'b0;
  endtask

  // halt, then count the stopped cycles until restart
  task automatic halt_measure(int exp, string req);
    int n;
    issue(i_halt());
    chk("R3", "run after halt", int'(run), 0);
    n = 1;
    while (!run && n < 400) begin
      step();
      if (!run) n++;
    end
    chk(req, "stopped cycles", n, exp);
    chk("R4", "pc_load at restart", int'(pc_load), 1);
    chk("R4", "pc_addr at restart", int'(pc_addr), int'(start_addr));
    step();
    chk("R2", "pc_load one cycle", int'(pc_load), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) step();
    // R1 reset state
    chk("R1", "run in reset", int'(run), 0);
    chk("R1", "pc_load in reset", int'(pc_load), 0);
    chk("R1", "wake in reset", int'(wake), 0);
    rst_ni = 1'b1;
    step();
    // R9 / R1: idle core ignores instructions and never self-starts
    issue(i_end(1'b1));
    chk("R9", "wake while idle", int'(wake), 0);
    issue(i_halt());
    repeat (20) step();
    chk("R1", "no self start", int'(run), 0);

    // R2 host start
    host_start = 1'b1;
    step();
    host_start = 1'b0;
    chk("R2", "run after start", int'(run), 1);
    chk("R2", "pc_load after start", int'(pc_load), 1);
    chk("R2", "pc_addr after start", int'(pc_addr), 16'h155);
    step();
    chk("R2", "pc_load falls", int'(pc_load), 0);

    // R5 default index 0
    halt_measure(per[0] + 1, "R5");

    // R5/R6 sweep all select values; index 1 gives a zero period (R4)
    for (int i = 0; i < 16; i++) begin
      int e;
      e = (i < NP) ? per[i] + 1 : per[NP-1] + 1;
      issue(i_sel(i));
      chk("R5", "run after select", int'(run), 1);
      halt_measure(e, (i < NP) ? "R5" : "R6");
    end

    // R4 zero period gives one stopped cycle
    issue(i_sel(1));
    halt_measure(1, "R4");

    // R7 wake pulse
    issue(i_end(1'b1));
    chk("R7", "wake pulse", int'(wake), 1);
    chk("R7", "run kept", int'(run), 1);
    step();
    chk("R7", "wake one cycle", int'(wake), 0);
    issue(i_end(1'b0));
    chk("R7", "no wake without flag", int'(wake), 0);

    // R9 instructions during sleep are ignored
    issue(i_sel(2));
    issue(i_halt());
    n = 1;
    issue(i_end(1'b1)); n++;
    chk("R9", "wake during sleep", int'(wake), 0);
    issue(i_sel(3)); n++;
    while (!run && n < 400) begin
      step();
      if (!run) n++;
    end
    chk("R9", "sleep length unchanged", n, per[2] + 1);
    step();
    halt_measure(per[2] + 1, "R9");

    // R8 clear while running
    tmr_clr = 1'b1; step(); tmr_clr = 1'b0;
    chk("R8", "runs on after clear", int'(run), 1);
    issue(i_halt());
    n = 0;
    repeat (40) begin step(); n += int'(run) + int'(pc_load); end
    chk("R8", "no restart after clear", n, 0);
    start();
    chk("R8", "host start after clear", int'(run), 1);

    // R8 clear while asleep
    issue(i_sel(3));
    issue(i_halt());
    step();
    tmr_clr = 1'b1; step(); tmr_clr = 1'b0;
    n = 0;
    repeat (40) begin step(); n += int'(run); end
    chk("R8", "no restart, clear in sleep", n, 0);
    start();
    chk("R8", "rearmed by start", int'(run), 1);
    halt_measure(per[3] + 1, "R8");

    // R2 host start beats halt in the same cycle
    host_start = 1'b1; insn_valid = 1'b1; insn = i_halt();
    step();
    host_start = 1'b0; insn_valid = 1'b0; insn = '0;
    chk("R2", "start wins over halt", int'(run), 1);
    chk("R10", "pc_load with run", int'(pc_load & run), int'(pc_load));

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule